// File: doc/BRIEF.md
# Line Wake-Up Pulse Detector

This block watches a half-duplex sensor line that the local side drives, and recognises a wake-up request. A remote device asks for wake-up by overriding the local driver, so that the line sits in a shorted state: the level on the wire disagrees with what the driver is trying to produce, or the driver reports overcurrent. The block qualifies such a short against the driven state and the driver's output mode. Once the short has lasted a minimum time, it emits one active-low pulse of fixed width.

The block also keeps a wake-up interrupt flag for a status register. The flag is raised at the moment the remote side lets go of the line, not when the short is first recognised. Raising it is gated by an interrupt-enable bit, and the flag is cleared by a strobe from the register block. All timing comes from counters on the system clock. The qualification and pulse lengths are given in microseconds and scaled by the clock rate in MHz. Every input is a clean, already-synchronised digital level, and there is no streaming data path.

Top module: `line_wake_detector`

## Requirements
- R1: After reset, `wake_n` is 1 and `wake_irq` is 0.
- R2: The short condition depends on `drv_mode`, and on none of the modes when `drv_en` is 0. With mode 0 (push-pull) or 3, the line is shorted when `line_lvl` differs from `drv_val` or when `ovc` is 1. With mode 1 (high-side), the switch is on only while `drv_val` is 1, and the line is shorted when the switch is on and either `line_lvl` is 0 or `ovc` is 1. With mode 2 (low-side), the switch is on only while `drv_val` is 0, and the line is shorted when the switch is on and either `line_lvl` is 1 or `ovc` is 1.
- R3: When the short is present on QUAL_CYC = CLK_MHZ*QUAL_US consecutive clock edges, `wake_n` is 0 from that last edge onward.
- R4: A short present on fewer than QUAL_CYC consecutive edges produces no pulse, and a break in the short restarts the count from zero.
- R5: `wake_n` stays 0 for exactly PULSE_CYC = CLK_MHZ*PULSE_US cycles and then returns to 1, even if the short is still present.
- R6: While `drv_en` is 0, no wake-up is recognised, whatever `line_lvl` and `ovc` do.
- R7: After a recognition, the first edge at which the short is absent sets `wake_irq`, provided `irq_en` is 1 at that edge. `wake_irq` is not set at the moment of recognition, and it is not set if `irq_en` is 0 at release.
- R8: `irq_en` has no effect on the timing or width of `wake_n`.
- R9: `wake_irq` stays 1 until an edge with `irq_clr` at 1. If a release set and a clear fall on the same edge, the flag ends up 1.
- R10: A new recognition is not accepted until both the pulse has completed and the line has been released. A short that continues past the end of the pulse never triggers a second pulse by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Line driver enabled |
| drv_mode | input | 2 | Driver mode: 0 push-pull, 1 high-side, 2 low-side, 3 as push-pull |
| drv_val | input | 1 | Logic value the driver is asked to produce |
| line_lvl | input | 1 | Sampled logic level on the line |
| ovc | input | 1 | Driver overcurrent indication |
| irq_en | input | 1 | Wake-up interrupt enable |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| wake_n | output | 1 | Active-low wake-up pulse |
| wake_irq | output | 1 | Wake-up interrupt flag |

## Verification
Suppose the qualification counter holds a stale value. The fall of `wake_n` then moves away from the exact QUAL_CYC-th short edge, or a brief glitch yields a pulse. Either shows at the port within one qualification window. A wrong pulse counter shows as a rising edge of `wake_n` one or more cycles away from PULSE_CYC after its fall. Suppose the arm and release tracking is corrupted. A held short then retriggers right after the pulse ends, or the interrupt flag rises at recognition instead of at release. Both are visible within one pulse length plus one cycle.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [1:0] {
    DRV_PUSHPULL = 2'd0,
    DRV_HIGHSIDE = 2'd1,
    DRV_LOWSIDE  = 2'd2,
    DRV_SPARE    = 2'd3
  } drv_mode_e;
endpackage

// File: rtl/wk_short_mon.sv
module wk_short_mon
  import wk_pkg::*;
(
  input  logic       drv_en,
  input  logic [1:0] drv_mode,
  input  logic       drv_val,
  input  logic       line_lvl,
  input  logic       ovc,
  output logic       short_o
);
  drv_mode_e mode;
  assign mode = drv_mode_e'(drv_mode);

  // Push-pull: any mismatch between wire and driven value is a fight.
  // Open-drain variants only fight while their switch conducts.
  always_comb begin
    short_o = 1'b0;
    if (drv_en) begin
      unique case (mode)
        DRV_HIGHSIDE: short_o = drv_val  & (~line_lvl | ovc);
        DRV_LOWSIDE:  short_o = ~drv_val & (line_lvl | ovc);
        default:      short_o = (line_lvl ^ drv_val) | ovc;
      endcase
    end
  end
endmodule

// File: rtl/wk_qual_timer.sv
module wk_qual_timer #(
  parameter int unsigned QUAL_CYC = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic short_i,
  output logic hit_o
);
  localparam int unsigned QW = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) : 1;
  localparam logic [QW-1:0] LAST = QW'(QUAL_CYC - 1);

  logic [QW-1:0] cnt;

  assign hit_o = arm & short_i & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!arm || !short_i) cnt <= '0;
    else if (cnt != LAST)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wk_pulse_gen.sv
module wk_pulse_gen #(
  parameter int unsigned PULSE_CYC = 190
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy_o
);
  localparam int unsigned PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PULSE_CYC - 1);

  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      left   <= '0;
    end else if (start) begin
      busy_o <= 1'b1;
      left   <= LAST;
    end else if (busy_o) begin
      if (left == '0) busy_o <= 1'b0;
      else            left   <= left - 1'b1;
    end
  end
endmodule

// File: rtl/line_wake_detector.sv
module line_wake_detector #(
  parameter int unsigned CLK_MHZ  = 200,
  parameter int unsigned QUAL_US  = 80,
  parameter int unsigned PULSE_US = 190
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drv_en,
  input  logic [1:0] drv_mode,
  input  logic       drv_val,
  input  logic       line_lvl,
  input  logic       ovc,
  input  logic       irq_en,
  input  logic       irq_clr,
  output logic       wake_n,
  output logic       wake_irq
);
  localparam int unsigned QUAL_CYC  = CLK_MHZ * QUAL_US;
  localparam int unsigned PULSE_CYC = CLK_MHZ * PULSE_US;

  logic short_w;
  logic hit;
  logic busy;
  logic armed;
  logic rel_seen;
  logic rel_edge;

  wk_short_mon u_mon (
    .drv_en   (drv_en),
    .drv_mode (drv_mode),
    .drv_val  (drv_val),
    .line_lvl (line_lvl),
    .ovc      (ovc),
    .short_o  (short_w)
  );

  wk_qual_timer #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (armed),
    .short_i (short_w),
    .hit_o   (hit)
  );

  wk_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (hit),
    .busy_o (busy)
  );

  // First edge without a short after a recognition.
  assign rel_edge = ~armed & ~rel_seen & ~short_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b1;
      rel_seen <= 1'b0;
    end else if (armed) begin
      if (hit) begin
        armed    <= 1'b0;
        rel_seen <= 1'b0;
      end
    end else begin
      if (rel_edge) rel_seen <= 1'b1;
      if ((rel_seen || !short_w) && !busy) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wake_irq <= 1'b0;
    else if (rel_edge && irq_en) wake_irq <= 1'b1;
    else if (irq_clr)            wake_irq <= 1'b0;
  end

  assign wake_n = ~busy;
endmodule

// File: rtl/wk_chk.sv
module wk_chk #(
  parameter int unsigned QUAL_CYC  = 80,
  parameter int unsigned PULSE_CYC = 190
) (
  input logic clk,
  input logic rst_n,
  input logic drv_en,
  input logic irq_en,
  input logic irq_clr,
  input logic short_w,
  input logic wake_n,
  input logic wake_irq
);
  localparam int unsigned SW = $clog2(QUAL_CYC + 2);
  localparam int unsigned LW = $clog2(PULSE_CYC + 2);

  logic [SW-1:0] scnt;
  logic [LW-1:0] lcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt <= '0;
      lcnt <= '0;
    end else begin
      if (!short_w)                  scnt <= '0;
      else if (scnt != SW'(QUAL_CYC)) scnt <= scnt + 1'b1;
      if (wake_n)                    lcnt <= '0;
      else if (lcnt != LW'(PULSE_CYC + 1)) lcnt <= lcnt + 1'b1;
    end
  end

  // R3
  qual_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_n) |-> (scnt >= SW'(QUAL_CYC)));

  // R6
  drv_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_n) |-> $past(drv_en));

  // R5
  pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_n |-> (lcnt < LW'(PULSE_CYC)));

  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_n) |-> (lcnt == LW'(PULSE_CYC)));

  // R7
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> $past(!short_w && irq_en));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !irq_clr) |=> wake_irq);
endmodule

bind line_wake_detector wk_chk #(
  .QUAL_CYC  (QUAL_CYC),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .drv_en   (drv_en),
  .irq_en   (irq_en),
  .irq_clr  (irq_clr),
  .short_w  (short_w),
  .wake_n   (wake_n),
  .wake_irq (wake_irq)
);

// File: tb/tb_line_wake_detector.sv
module tb_line_wake_detector;
  localparam int Q = 80;
  localparam int P = 190;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drv_en = 1'b0;
  logic [1:0] drv_mode = 2'd0;
  logic drv_val = 1'b1;
  logic line_lvl = 1'b1;
  logic ovc = 1'b0;
  logic irq_en = 1'b0;
  logic irq_clr = 1'b0;
  logic wake_n;
  logic wake_irq;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  line_wake_detector #(.CLK_MHZ(1), .QUAL_US(80), .PULSE_US(190)) dut (
    .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .drv_mode(drv_mode),
    .drv_val(drv_val), .line_lvl(line_lvl), .ovc(ovc), .irq_en(irq_en),
    .irq_clr(irq_clr), .wake_n(wake_n), .wake_irq(wake_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Push-pull fight: wire opposes driven value
  task automatic pp_short(input bit s);
    line_lvl = drv_val ^ s;
  endtask

  // Apply short at a negedge, then check wake_n at negedge Q-1 / Q / Q+P-1 / Q+P
  task automatic detect_and_time(input string req);
    int low_at = -1;
    int high_at = -1;
    for (int i = 1; i <= Q + P + 2; i++) begin
      @(negedge clk);
      if (i == Q - 1) check(wake_n == 1'b1, req, wake_n, 1);
      if (i == Q)     check(wake_n == 1'b0, req, wake_n, 0);
      if (i == Q + P - 1) check(wake_n == 1'b0, "R5", wake_n, 0);
      if (i == Q + P)     check(wake_n == 1'b1, "R5", wake_n, 1);
    end
  endtask

  task automatic settle();
    drv_mode = 2'd0; drv_val = 1'b1; line_lvl = 1'b1; ovc = 1'b0; drv_en = 1'b1;
    irq_clr = 1'b1; tick(Q + P + 4); irq_clr = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    check(wake_n == 1'b1, "R1", wake_n, 1);
    check(wake_irq == 1'b0, "R1", wake_irq, 0);
  endtask

  // Main push-pull path, short held past pulse, then release with irq enabled
  task automatic t_pp_main();
    bit seen_low = 0;
    settle(); irq_en = 1'b1;
    pp_short(1'b1);
    detect_and_time("R3");
    check(wake_irq == 1'b0, "R7", wake_irq, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!wake_n) seen_low = 1;
    end
    check(!seen_low, "R10", seen_low, 0);
    pp_short(1'b0);
    @(negedge clk);
    check(wake_irq == 1'b1, "R7", wake_irq, 1);
    tick(5);
    check(wake_irq == 1'b1, "R9", wake_irq, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check(wake_irq == 1'b0, "R9", wake_irq, 0);
  endtask

  task automatic t_glitch();
    bit seen_low = 0;
    settle();
    for (int k = 0; k < 3; k++) begin
      pp_short(1'b1); tick(Q - 1);
      pp_short(1'b0); tick(1);
    end
    for (int i = 0; i < Q + 3; i++) begin
      @(negedge clk);
      if (!wake_n) seen_low = 1;
    end
    check(!seen_low, "R4", seen_low, 0);
  endtask

  task automatic t_drv_off();
    bit seen_low = 0;
    settle(); drv_en = 1'b0; irq_en = 1'b1;
    line_lvl = 1'b0; ovc = 1'b1;
    for (int i = 0; i < Q + P; i++) begin
      @(negedge clk);
      if (!wake_n) seen_low = 1;
    end
    ovc = 1'b0; line_lvl = 1'b1; tick(2);
    check(!seen_low, "R6", seen_low, 0);
    check(wake_irq == 1'b0, "R6", wake_irq, 0);
  endtask

  task automatic t_modes();
    bit seen_low = 0;
    // High-side, switch off: wire low is not a fight
    settle(); drv_mode = 2'd1; drv_val = 1'b0; line_lvl = 1'b0;
    for (int i = 0; i < Q + 3; i++) begin
      @(negedge clk);
      if (!wake_n) seen_low = 1;
    end
    check(!seen_low, "R2", seen_low, 0);
    drv_val = 1'b1;
    detect_and_time("R2");
    // Low-side, switch on, wire pulled high
    settle(); drv_mode = 2'd2; drv_val = 1'b0; line_lvl = 1'b1;
    detect_and_time("R2");
    // Low-side switch off with wire high: no fight
    settle(); drv_mode = 2'd2; drv_val = 1'b1; line_lvl = 1'b1; ovc = 1'b1;
    seen_low = 0;
    for (int i = 0; i < Q + 3; i++) begin
      @(negedge clk);
      if (!wake_n) seen_low = 1;
    end
    check(!seen_low, "R2", seen_low, 0);
    // Push-pull with matching wire but overcurrent
    settle(); drv_val = 1'b1; line_lvl = 1'b1; ovc = 1'b1;
    detect_and_time("R2");
  endtask

  task automatic t_irq_off();
    settle(); irq_en = 1'b0;
    pp_short(1'b1);
    detect_and_time("R8");
    pp_short(1'b0); tick(3);
    check(wake_irq == 1'b0, "R7", wake_irq, 0);
  endtask

  task automatic t_set_wins();
    settle(); irq_en = 1'b1;
    pp_short(1'b1); tick(Q + 2);
    pp_short(1'b0); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check(wake_irq == 1'b1, "R9", wake_irq, 1);
  endtask

  // Release during pulse, re-short at once: next pulse only after first ends
  task automatic t_rearm();
    int first_low = -1;
    bit early = 0;
    settle(); irq_en = 1'b0;
    pp_short(1'b1); tick(Q + 5);
    pp_short(1'b0); tick(1);
    pp_short(1'b1);
    for (int i = Q + 7; i <= Q + P + Q + 6; i++) begin
      @(negedge clk);
      if (i == Q + P) check(wake_n == 1'b1, "R10", wake_n, 1);
      if (!wake_n && i > Q + P && first_low < 0) first_low = i;
    end
    if (first_low >= 0 && first_low < Q + P + Q) early = 1;
    check(first_low >= 0 && !early, "R10", first_low, Q + P + Q);
    pp_short(1'b0);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_pp_main();
    t_glitch();
    t_drv_off();
    t_modes();
    t_irq_off();
    t_set_wins();
    t_rearm();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule